// File: doc/BRIEF.md
# Block-Mode Peripheral DMA Channel

This block is one DMA channel that copies a run of 32-bit words between system memory and a single peripheral. Software programs three registers through a small register bus: a memory address (select 0), a block-control word (select 1) and a channel-control word (select 2). The number of words moved is the product of the upper and lower 16-bit halves of the block-control word.

Writing one of two exact command values to the control register starts a transfer. 0x01000201 moves memory to the peripheral and 0x01000200 moves the peripheral to memory. Any other value is stored with bit 24 cleared and completes at once with an interrupt, without moving data. During a transfer the channel reads or writes memory through a request/acknowledge master port, one word at a time at ascending addresses. It exchanges data with the peripheral over valid/ready ports. When the transfer ends, the address register points just past the last word, bit 24 of the control register drops, and a one-cycle interrupt pulse is raised in the same cycle.

A parameter selects a 16-bit peripheral port. In that mode each word crosses the port as two halfwords.

Top module: `blk_dma_chan`

## Requirements
- R1: After reset the address, block and control registers read 0 at selects 0, 1 and 2, `dmaIrq` is low, and `memReq`, `txValid` and `rxReady` are low.
- R2: Writing 0x01000201 to the control register while idle reads words from memory at ascending byte addresses, stepping by 4 from the address register. The words are presented on the transmit port in that order.
- R3: Writing 0x01000200 to the control register while idle takes words from the receive port in arrival order. Each word is written to memory at ascending byte addresses, stepping by 4 from the address register.
- R4: The number of words moved equals block-control bits [31:16] multiplied by bits [15:0].
- R5: After completion the address register reads the start address plus 4 times the number of words moved.
- R6: Control bit 24 reads 1 for the whole transfer. It reads 0 from the cycle in which `dmaIrq` pulses high for exactly one cycle at completion.
- R7: A control write of any value other than the two commands stores that value with bit 24 cleared. `dmaIrq` pulses in the cycle after the write, and there is no memory or port activity.
- R8: With the 16-bit port, each word is sent or received as two beats: bits [15:0] first, then bits [31:16].
- R9: `txValid` with its data, and `memReq` with its address and direction, stay unchanged until `txReady` or `memAck` respectively is seen high.
- R10: Writes to the address, block or control register while a transfer is in progress have no effect.
- R11: A command with a zero word count raises `dmaIrq` and clears bit 24 two cycles after the write. It leaves the address unchanged and moves no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select for writes and reads (0 address, 1 block, 2 control) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the selected register |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | ADDR_W | Memory byte address |
| memWData | output | 32 | Memory write data |
| memRData | input | 32 | Memory read data, valid with `memAck` |
| memAck | input | 1 | Memory access completes this cycle |
| txValid | output | 1 | Transmit beat valid |
| txData | output | PORT_W | Transmit beat data |
| txReady | input | 1 | Peripheral accepts the transmit beat |
| rxValid | input | 1 | Receive beat valid |
| rxData | input | PORT_W | Receive beat data |
| rxReady | output | 1 | Channel accepts a receive beat |
| dmaIrq | output | 1 | One-cycle completion interrupt |

## Verification
The bench builds the channel with `HALF_PORT = 1` and a 24-bit address. This puts the two-beat split and merge of each word, and the low-half-first order, under every transfer. Memory acknowledge, transmit ready and receive valid each stall on their own repeating pattern. Stalls therefore land mid-word, between halves and between words, which brings the hold-until-handshake rule and busy-time register writes within reach. Block words with unequal halves, unrecognised commands and a zero-length command cover the count product, the no-move completion paths and the address arithmetic.

// File: rtl/blk_dma_pkg.sv
package blk_dma_pkg;

  localparam logic [31:0] CMD_TO_PORT   = 32'h0100_0201;
  localparam logic [31:0] CMD_FROM_PORT = 32'h0100_0200;
  localparam int          BUSY_POS      = 24;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_BLK  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEM_RD,
    ST_PORT_TX,
    ST_PORT_RX,
    ST_MEM_WR,
    ST_FINISH
  } chanState_t;

  typedef struct packed {
    logic wrAddr;
    logic wrBlk;
    logic wrCtrl;
    logic dropBusy;
    logic loadCount;
    logic capMem;
    logic capPort;
    logic stepBeat;
    logic finishWord;
  } dpStrobe_t;

endpackage

// File: rtl/blk_dma_ctrl.sv
module blk_dma_ctrl
  import blk_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regSel,
  input  logic [31:0] regWrData,
  input  logic        blkZero,
  input  logic        lastWord,
  input  logic        lastBeat,
  input  logic        memAck,
  input  logic        txReady,
  input  logic        rxValid,
  output dpStrobe_t   strobe,
  output logic        memReq,
  output logic        memWe,
  output logic        txValid,
  output logic        rxReady,
  output logic        busy,
  output logic        irq
);

  chanState_t state, nextState;
  logic irqSet;
  logic cmdHit;

  assign cmdHit = (regWrData == CMD_TO_PORT) || (regWrData == CMD_FROM_PORT);

  always_comb begin
    strobe    = '0;
    nextState = state;
    memReq    = 1'b0;
    memWe     = 1'b0;
    txValid   = 1'b0;
    rxReady   = 1'b0;
    irqSet    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (regWrEn) begin
          case (regSel)
            SEL_ADDR: strobe.wrAddr = 1'b1;
            SEL_BLK:  strobe.wrBlk  = 1'b1;
            SEL_CTRL: begin
              strobe.wrCtrl = 1'b1;
              if (regWrData == CMD_TO_PORT) begin
                strobe.loadCount = 1'b1;
                nextState = blkZero ? ST_FINISH : ST_MEM_RD;
              end else if (regWrData == CMD_FROM_PORT) begin
                strobe.loadCount = 1'b1;
                nextState = blkZero ? ST_FINISH : ST_PORT_RX;
              end else begin
                strobe.dropBusy = 1'b1;
                irqSet = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
      ST_MEM_RD: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.capMem = 1'b1;
          nextState = ST_PORT_TX;
        end
      end
      ST_PORT_TX: begin
        txValid = 1'b1;
        if (txReady) begin
          strobe.stepBeat = 1'b1;
          if (lastBeat) begin
            strobe.finishWord = 1'b1;
            nextState = lastWord ? ST_FINISH : ST_MEM_RD;
          end
        end
      end
      ST_PORT_RX: begin
        rxReady = 1'b1;
        if (rxValid) begin
          strobe.capPort  = 1'b1;
          strobe.stepBeat = 1'b1;
          if (lastBeat) nextState = ST_MEM_WR;
        end
      end
      ST_MEM_WR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          strobe.finishWord = 1'b1;
          nextState = lastWord ? ST_FINISH : ST_PORT_RX;
        end
      end
      ST_FINISH: begin
        strobe.dropBusy = 1'b1;
        irqSet = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      irq   <= 1'b0;
    end else begin
      state <= nextState;
      irq   <= irqSet;
    end
  end

  assign busy = (state != ST_IDLE);

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid);

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWe));

  // R11
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && regWrEn && regSel == SEL_CTRL && cmdHit && blkZero |=> ##1 irq);

endmodule

// File: rtl/blk_dma_dpath.sv
module blk_dma_dpath
  import blk_dma_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter bit HALF_PORT = 1'b1,
  localparam int PORT_W   = HALF_PORT ? 16 : 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [1:0]        regSel,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [31:0]       memRData,
  input  logic [PORT_W-1:0] rxData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWData,
  output logic [PORT_W-1:0] txData,
  output logic              blkZero,
  output logic              lastWord,
  output logic              lastBeat,
  output logic              busyBit
);

  localparam logic [31:0] BUSY_MASK = 32'(1) << BUSY_POS;

  logic [ADDR_W-1:0] addrReg;
  logic [31:0]       blkReg;
  logic [31:0]       ctrlReg;
  logic [31:0]       wordsLeft;
  logic [31:0]       dataBuf;
  logic              beatSel;
  logic [31:0]       portMerged;

  generate
    if (HALF_PORT) begin : g_half
      assign portMerged = beatSel ? {rxData, dataBuf[15:0]} : {dataBuf[31:16], rxData};
      assign txData     = beatSel ? dataBuf[31:16] : dataBuf[15:0];
      assign lastBeat   = beatSel;
    end else begin : g_full
      assign portMerged = rxData;
      assign txData     = dataBuf;
      assign lastBeat   = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      blkReg    <= '0;
      ctrlReg   <= '0;
      wordsLeft <= '0;
      dataBuf   <= '0;
      beatSel   <= 1'b0;
    end else begin
      if (strobe.wrAddr)          addrReg <= regWrData[ADDR_W-1:0];
      else if (strobe.finishWord) addrReg <= addrReg + ADDR_W'(4);

      if (strobe.wrBlk) blkReg <= regWrData;

      if (strobe.wrCtrl)
        ctrlReg <= strobe.dropBusy ? (regWrData & ~BUSY_MASK) : regWrData;
      else if (strobe.dropBusy)
        ctrlReg <= ctrlReg & ~BUSY_MASK;

      if (strobe.loadCount)
        wordsLeft <= 32'(blkReg[31:16]) * 32'(blkReg[15:0]);
      else if (strobe.finishWord)
        wordsLeft <= wordsLeft - 32'd1;

      if (strobe.capMem)       dataBuf <= memRData;
      else if (strobe.capPort) dataBuf <= portMerged;

      if (strobe.finishWord)    beatSel <= 1'b0;
      else if (strobe.stepBeat) beatSel <= ~beatSel;
    end
  end

  always_comb begin
    case (regSel)
      SEL_ADDR: regRdData = 32'(addrReg);
      SEL_BLK:  regRdData = blkReg;
      SEL_CTRL: regRdData = ctrlReg;
      default:  regRdData = '0;
    endcase
  end

  assign memAddr  = addrReg;
  assign memWData = dataBuf;
  assign blkZero  = (blkReg[31:16] == 16'd0) || (blkReg[15:0] == 16'd0);
  assign lastWord = (wordsLeft == 32'd1);
  assign busyBit  = ctrlReg[BUSY_POS];

endmodule

// File: rtl/blk_dma_chan.sv
module blk_dma_chan
  import blk_dma_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter bit HALF_PORT = 1'b1,
  localparam int PORT_W   = HALF_PORT ? 16 : 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWData,
  input  logic [31:0]       memRData,
  input  logic              memAck,
  output logic              txValid,
  output logic [PORT_W-1:0] txData,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [PORT_W-1:0] rxData,
  output logic              rxReady,
  output logic              dmaIrq
);

  dpStrobe_t strobe;
  logic blkZero, lastWord, lastBeat, busy, busyBit;

  blk_dma_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .blkZero(blkZero), .lastWord(lastWord), .lastBeat(lastBeat),
    .memAck(memAck), .txReady(txReady), .rxValid(rxValid),
    .strobe(strobe), .memReq(memReq), .memWe(memWe),
    .txValid(txValid), .rxReady(rxReady), .busy(busy), .irq(dmaIrq)
  );

  blk_dma_dpath #(.ADDR_W(ADDR_W), .HALF_PORT(HALF_PORT)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .memRData(memRData), .rxData(rxData),
    .memAddr(memAddr), .memWData(memWData), .txData(txData),
    .blkZero(blkZero), .lastWord(lastWord), .lastBeat(lastBeat),
    .busyBit(busyBit)
  );

  // R6
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> busyBit);

  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaIrq |-> !busyBit);

  // R9
  tx_data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> $stable(txData));

endmodule

// File: tb/blk_dma_chan_tb_top.sv
module blk_dma_chan_tb_top;

  localparam int ADDR_W = 24;
  localparam int PORT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic memReq, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0] memWData;
  logic [31:0] memRData = '0;
  logic memAck = 1'b0;
  logic txValid;
  logic [PORT_W-1:0] txData;
  logic txReady = 1'b0;
  logic rxValid = 1'b0;
  logic [PORT_W-1:0] rxData = '0;
  logic rxReady;
  logic dmaIrq;

  always #5 clk = ~clk;

  blk_dma_chan #(.ADDR_W(ADDR_W), .HALF_PORT(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memRData(memRData), .memAck(memAck),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady), .dmaIrq(dmaIrq)
  );

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  int irqCount = 0;
  int actCount = 0;
  bit finished = 1'b0;
  logic [31:0] mem [256];
  logic [15:0] txExp[$];
  logic [15:0] rxSrc[$];
  logic [31:0] wrAddrExp[$];
  logic [31:0] wrDataExp[$];
  bit txStall = 1'b0;
  logic [15:0] txHold = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference environment, evaluated every clock away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (txStall) chk("R9 transmit hold", {15'd0, txValid, txData}, {15'd0, 1'b1, txHold});
      txReady = (cyc % 3) != 0;
      txStall = txValid && !txReady;
      txHold  = txData;
      if (txValid && txReady) begin
        if (txExp.size() == 0) chk("R2 unexpected transmit beat", 32'd1, 32'd0);
        else chk("R2 R8 transmit beat", 32'(txData), 32'(txExp.pop_front()));
      end
      memAck = memReq && ((cyc % 4) != 1);
      if (memReq && !memWe) memRData = mem[memAddr[9:2]];
      if (memReq && memAck && memWe) begin
        if (wrAddrExp.size() == 0) chk("R3 unexpected memory write", 32'd1, 32'd0);
        else begin
          chk("R3 write address", 32'(memAddr), wrAddrExp.pop_front());
          chk("R3 R8 write data", memWData, wrDataExp.pop_front());
        end
        mem[memAddr[9:2]] = memWData;
      end
      rxValid = (rxSrc.size() > 0) && ((cyc % 5) != 2);
      rxData  = (rxSrc.size() > 0) ? rxSrc[0] : 16'd0;
      if (rxValid && rxReady) void'(rxSrc.pop_front());
      if (dmaIrq) irqCount++;
      if (memReq || txValid || rxReady) actCount++;
    end
  end

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    regSel = sel; regWrData = data; regWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, output logic [31:0] val);
    regSel = sel;
    #1;
    val = regRdData;
  endtask

  task automatic waitIrq();
    int n = 0;
    while (!dmaIrq && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk("R6 completion interrupt", 32'(dmaIrq), 32'd1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  task automatic runToPort(logic [31:0] addr, logic [31:0] blk);
    logic [31:0] v;
    int n = int'(blk[31:16]) * int'(blk[15:0]);
    int irq0;
    wr(2'd0, addr);
    wr(2'd1, blk);
    for (int w = 0; w < n; w++) begin
      v = mem[(addr[9:2] + w) % 256];
      txExp.push_back(v[15:0]);
      txExp.push_back(v[31:16]);
    end
    irq0 = irqCount;
    wr(2'd2, 32'h0100_0201);
    waitIrq();
    rd(2'd2, v);
    chk("R6 busy cleared with interrupt", v, 32'h0000_0201);
    repeat (3) @(negedge clk);
    chk("R4 all beats sent", 32'(txExp.size()), 32'd0);
    chk("R6 single interrupt pulse", 32'(irqCount - irq0), 32'd1);
    rd(2'd0, v);
    chk("R5 final address", v, addr + 32'(4 * n));
  endtask

  initial begin
    logic [31:0] v;
    int act0, irq0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h1000_0000 + 32'(i) * 32'h0003_0101;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 address reset", v, 32'd0);
    rd(2'd1, v); chk("R1 block reset", v, 32'd0);
    rd(2'd2, v); chk("R1 control reset", v, 32'd0);
    chk("R1 idle outputs", {28'd0, dmaIrq, memReq, txValid, rxReady}, 32'd0);

    // R2 R4 R8 R10: memory to port, 3 blocks of 2 words, with busy-time writes
    wr(2'd0, 32'h40);
    wr(2'd1, 32'h0003_0002);
    for (int w = 0; w < 6; w++) begin
      txExp.push_back(mem[16 + w][15:0]);
      txExp.push_back(mem[16 + w][31:16]);
    end
    irq0 = irqCount;
    wr(2'd2, 32'h0100_0201);
    repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R6 busy during transfer", v, 32'h0100_0201);
    wr(2'd0, 32'h999);
    wr(2'd1, 32'h0000_0007);
    wr(2'd2, 32'h0100_0200);
    rd(2'd1, v); chk("R10 block write ignored", v, 32'h0003_0002);
    rd(2'd2, v); chk("R10 control write ignored", v, 32'h0100_0201);
    waitIrq();
    rd(2'd2, v); chk("R6 busy cleared with interrupt", v, 32'h0000_0201);
    repeat (3) @(negedge clk);
    chk("R4 twelve beats sent", 32'(txExp.size()), 32'd0);
    chk("R6 single interrupt pulse", 32'(irqCount - irq0), 32'd1);
    rd(2'd0, v); chk("R5 R10 final address", v, 32'h58);

    // R3 R8: port to memory, 2 blocks of 2 words
    wr(2'd0, 32'h100);
    wr(2'd1, 32'h0002_0002);
    for (int w = 0; w < 4; w++) begin
      v = 32'hC0DE_0000 ^ (32'(w) * 32'h1111_0001);
      rxSrc.push_back(v[15:0]);
      rxSrc.push_back(v[31:16]);
      wrAddrExp.push_back(32'h100 + 32'(4 * w));
      wrDataExp.push_back(v);
    end
    wr(2'd2, 32'h0100_0200);
    waitIrq();
    repeat (3) @(negedge clk);
    chk("R3 R4 all writes done", 32'(wrAddrExp.size()), 32'd0);
    chk("R8 all halves taken", 32'(rxSrc.size()), 32'd0);
    chk("R3 stored word", mem[64 + 3], 32'hC0DE_0000 ^ (32'd3 * 32'h1111_0001));
    rd(2'd0, v); chk("R5 final address", v, 32'h110);

    // R4 R5: uneven halves, 1 block of 3 words
    runToPort(32'h200, 32'h0001_0003);

    // R7: unrecognised commands
    act0 = actCount;
    wr(2'd2, 32'h0100_0001);
    chk("R7 interrupt after bad command", 32'(dmaIrq), 32'd1);
    rd(2'd2, v); chk("R7 stored with busy cleared", v, 32'h0000_0001);
    @(negedge clk);
    chk("R7 interrupt is one cycle", 32'(dmaIrq), 32'd0);
    wr(2'd2, 32'h1100_0002);
    chk("R7 interrupt after second bad command", 32'(dmaIrq), 32'd1);
    rd(2'd2, v); chk("R7 second value stored", v, 32'h1000_0002);
    repeat (3) @(negedge clk);
    chk("R7 no activity", 32'(actCount - act0), 32'd0);
    rd(2'd0, v); chk("R7 address unchanged", v, 32'h20C);

    // R11: zero word count
    act0 = actCount;
    wr(2'd1, 32'h0005_0000);
    wr(2'd2, 32'h0100_0201);
    chk("R11 no interrupt one cycle after", 32'(dmaIrq), 32'd0);
    @(negedge clk);
    chk("R11 interrupt two cycles after", 32'(dmaIrq), 32'd1);
    rd(2'd2, v); chk("R11 busy cleared", v, 32'h0000_0201);
    repeat (3) @(negedge clk);
    chk("R11 no activity", 32'(actCount - act0), 32'd0);
    rd(2'd0, v); chk("R11 address unchanged", v, 32'h20C);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule